// File: doc/BRIEF.md
# Word Load/Store Address and Transfer Unit

This unit carries out the memory side of the two word-sized transfer instructions. It takes a 32-bit instruction word together with the value of its base register and the value of its data register. It adds the sign-extended 16-bit displacement to the base, with wraparound modulo 2^32. It then checks that the resulting byte address falls on a word boundary. On a legal address it issues exactly one memory request: a read strobe for a load, or a write strobe with write data for a store.

Load data comes back from the memory one cycle after the read strobe. The unit latches that data and presents it as a register writeback aimed at the instruction's second register field. A misaligned address raises an address-error pulse instead of a strobe. The unit accepts one request at a time and only while idle. Instruction words carrying any other opcode are ignored.

Top module: `mem_xfer_agu`

## Requirements
- R1: The address on `mem_addr`, in the cycle after a request is accepted, equals `base_val` plus the sign extension of `instr[15:0]`, taken modulo 2^32.
- R2: An accepted instruction with `instr[31:26]` = 0x23 (load) and an aligned address drives `mem_rd` high for exactly one cycle, the cycle after acceptance, with `mem_wr` low.
- R3: An accepted instruction with `instr[31:26]` = 0x2B (store) and an aligned address drives `mem_wr` high for exactly one cycle, the cycle after acceptance, with `mem_wdata` equal to the `store_val` sampled at acceptance.
- R4: When the effective address has a nonzero value in bits [1:0], `addr_fault` pulses for one cycle, the cycle after acceptance. In that case neither strobe is raised and no writeback follows.
- R5: Load data is taken from `mem_rdata` in the cycle after `mem_rd`. One cycle later `wb_en` pulses for a single cycle, with `wb_data` holding that word and `wb_reg` equal to `instr[20:16]` of the load.
- R6: `issue_ready` is high only while the unit is idle. An `issue_valid` seen while `issue_ready` is low is ignored and causes no strobe.
- R7: An instruction word whose opcode is neither 0x23 nor 0x2B is ignored. It produces no strobe, no fault and no writeback, and `issue_ready` stays high.
- R8: A store causes no writeback.
- R9: After reset, `issue_ready` is high and `mem_rd`, `mem_wr`, `addr_fault` and `wb_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_valid | input | 1 | A request is offered this cycle |
| issue_ready | output | 1 | Unit idle, a request can be accepted |
| instr | input | 32 | Instruction word: opcode, base field, data register field, displacement |
| base_val | input | 32 | Value of the base register |
| store_val | input | 32 | Value of the data register (store source) |
| mem_addr | output | 32 | Byte address of the request |
| mem_rd | output | 1 | Read strobe, one cycle |
| mem_wr | output | 1 | Write strobe, one cycle |
| mem_wdata | output | 32 | Write data for a store |
| mem_rdata | input | 32 | Read data, valid the cycle after `mem_rd` |
| addr_fault | output | 1 | Misaligned-address pulse |
| wb_en | output | 1 | Register writeback strobe |
| wb_reg | output | 5 | Writeback destination register index |
| wb_data | output | 32 | Writeback data |

## Verification
The displacement is aimed at wraparound in both directions: a base near the top of memory plus a positive offset, and the most negative offset applied to a small base. A unit that zero-extended the displacement, or that dropped the carry, would show a wrong address there. Misaligned loads and stores are issued to confirm that no strobe leaks out and no late writeback appears. A unit that trapped but still pulsed a strobe would corrupt memory.

The writeback is sampled exactly two cycles after the read strobe. A unit that captured read data one cycle early would write back stale data. Requests offered while the unit is busy, and instruction words with foreign opcodes, are checked to make sure they start nothing. A unit that accepted requests while busy would emit a stray write in the middle of a load.

// File: rtl/agu_pkg.sv
package agu_pkg;

   localparam logic [5:0] OPC_LDW = 6'h23;
   localparam logic [5:0] OPC_STW = 6'h2B;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_ISSUE,
      SQ_DATA,
      SQ_WB
   } seq_state_t;

   typedef enum logic [1:0] {
      XK_NONE,
      XK_LOAD,
      XK_STORE
   } xfer_kind_t;

endpackage

// File: rtl/agu_sum.sv
module agu_sum #(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 16
) (
   input  logic [ADDR_W-1:0] base_i,
   input  logic [OFF_W-1:0]  off_i,
   output logic [ADDR_W-1:0] ea_o
);
   localparam int EXT_W = ADDR_W - OFF_W;

   logic [ADDR_W-1:0] off_ext;

   generate
      if (EXT_W == 0) begin : g_noext
         assign off_ext = off_i;
      end else begin : g_sext
         assign off_ext = {{EXT_W{off_i[OFF_W-1]}}, off_i};
      end
   endgenerate

   assign ea_o = base_i + off_ext;
endmodule

// File: rtl/agu_align.sv
module agu_align #(
   parameter int ADDR_W       = 32,
   parameter int LOW_BITS     = 2,
   parameter bit STRICT_ALIGN = 1'b1
) (
   input  logic [ADDR_W-1:0] ea_i,
   output logic [ADDR_W-1:0] ea_o,
   output logic              misal_o
);
   generate
      if (STRICT_ALIGN) begin : g_trap
         assign ea_o    = ea_i;
         assign misal_o = |ea_i[LOW_BITS-1:0];
      end else begin : g_mask
         logic unused_low;
         assign unused_low = ^ea_i[LOW_BITS-1:0];
         assign ea_o       = {ea_i[ADDR_W-1:LOW_BITS], {LOW_BITS{1'b0}}};
         assign misal_o    = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/agu_seq.sv
module agu_seq
   import agu_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int REG_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  xfer_kind_t        kind_i,
   input  logic              fault_i,
   input  logic [ADDR_W-1:0] ea_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [REG_W-1:0]  rt_i,
   input  logic [DATA_W-1:0] rdata_i,
   output logic              ready_o,
   output logic              rd_o,
   output logic              wr_o,
   output logic              fault_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] wdata_o,
   output logic              wb_en_o,
   output logic [REG_W-1:0]  wb_reg_o,
   output logic [DATA_W-1:0] wb_data_o
);
   seq_state_t        state;
   xfer_kind_t        kind_q;
   logic              fault_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [REG_W-1:0]  rt_q;
   logic [DATA_W-1:0] wbd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= SQ_IDLE;
         kind_q  <= XK_NONE;
         fault_q <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
         rt_q    <= '0;
         wbd_q   <= '0;
      end else begin
         case (state)
            SQ_IDLE: begin
               if (start_i) begin
                  state   <= SQ_ISSUE;
                  kind_q  <= kind_i;
                  fault_q <= fault_i;
                  addr_q  <= ea_i;
                  wdata_q <= wdata_i;
                  rt_q    <= rt_i;
               end
            end
            SQ_ISSUE: begin
               if (kind_q == XK_LOAD && !fault_q) state <= SQ_DATA;
               else                               state <= SQ_IDLE;
            end
            SQ_DATA: begin
               wbd_q <= rdata_i;
               state <= SQ_WB;
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   assign ready_o   = (state == SQ_IDLE);
   assign rd_o      = (state == SQ_ISSUE) && (kind_q == XK_LOAD)  && !fault_q;
   assign wr_o      = (state == SQ_ISSUE) && (kind_q == XK_STORE) && !fault_q;
   assign fault_o   = (state == SQ_ISSUE) && fault_q;
   assign addr_o    = addr_q;
   assign wdata_o   = wdata_q;
   assign wb_en_o   = (state == SQ_WB);
   assign wb_reg_o  = rt_q;
   assign wb_data_o = wbd_q;
endmodule

// File: rtl/mem_xfer_agu.sv
module mem_xfer_agu
   import agu_pkg::*;
#(
   parameter int ADDR_W       = 32,
   parameter int DATA_W       = 32,
   parameter int INSTR_W      = 32,
   parameter int OFF_W        = 16,
   parameter int REG_W        = 5,
   parameter int OPC_W        = 6,
   parameter bit STRICT_ALIGN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               issue_valid,
   output logic               issue_ready,
   input  logic [INSTR_W-1:0] instr,
   input  logic [ADDR_W-1:0]  base_val,
   input  logic [DATA_W-1:0]  store_val,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic               mem_rd,
   output logic               mem_wr,
   output logic [DATA_W-1:0]  mem_wdata,
   input  logic [DATA_W-1:0]  mem_rdata,
   output logic               addr_fault,
   output logic               wb_en,
   output logic [REG_W-1:0]   wb_reg,
   output logic [DATA_W-1:0]  wb_data
);
   localparam int LOW_BITS = $clog2(DATA_W / 8);
   localparam int RT_LSB   = OFF_W;
   localparam int RS_LSB   = OFF_W + REG_W;
   localparam int OPC_LSB  = INSTR_W - OPC_W;

   generate
      if (DATA_W % 8 != 0 || DATA_W < 16) begin : g_bad_data
         $error("mem_xfer_agu: DATA_W must be a byte multiple of at least 16");
      end
      if (OFF_W > ADDR_W) begin : g_bad_off
         $error("mem_xfer_agu: OFF_W must not exceed ADDR_W");
      end
      if (OPC_W != 6 || OPC_LSB != RS_LSB + REG_W) begin : g_bad_fmt
         $error("mem_xfer_agu: instruction fields do not tile the word");
      end
   endgenerate

   logic [OPC_W-1:0]  opc;
   logic [REG_W-1:0]  rt_f;
   logic [OFF_W-1:0]  off_f;
   logic              unused_rs;
   xfer_kind_t        kind;
   logic              start;
   logic [ADDR_W-1:0] ea_raw;
   logic [ADDR_W-1:0] ea_fin;
   logic              misal;

   assign opc       = instr[INSTR_W-1:OPC_LSB];
   assign rt_f      = instr[RT_LSB+REG_W-1:RT_LSB];
   assign off_f     = instr[OFF_W-1:0];
   assign unused_rs = ^instr[RS_LSB+REG_W-1:RS_LSB];

   always_comb begin
      if (opc == OPC_LDW)      kind = XK_LOAD;
      else if (opc == OPC_STW) kind = XK_STORE;
      else                     kind = XK_NONE;
   end

   assign start = issue_valid && (kind != XK_NONE);

   agu_sum #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_sum (
      .base_i (base_val),
      .off_i  (off_f),
      .ea_o   (ea_raw)
   );

   agu_align #(.ADDR_W(ADDR_W), .LOW_BITS(LOW_BITS), .STRICT_ALIGN(STRICT_ALIGN)) u_align (
      .ea_i    (ea_raw),
      .ea_o    (ea_fin),
      .misal_o (misal)
   );

   agu_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_W(REG_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start),
      .kind_i    (kind),
      .fault_i   (misal),
      .ea_i      (ea_fin),
      .wdata_i   (store_val),
      .rt_i      (rt_f),
      .rdata_i   (mem_rdata),
      .ready_o   (issue_ready),
      .rd_o      (mem_rd),
      .wr_o      (mem_wr),
      .fault_o   (addr_fault),
      .addr_o    (mem_addr),
      .wdata_o   (mem_wdata),
      .wb_en_o   (wb_en),
      .wb_reg_o  (wb_reg),
      .wb_data_o (wb_data)
   );
endmodule

// File: rtl/agu_chk.sv
module agu_chk #(
   parameter int ADDR_W       = 32,
   parameter int DATA_W       = 32,
   parameter int INSTR_W      = 32,
   parameter bit STRICT_ALIGN = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               issue_valid,
   input logic               issue_ready,
   input logic [INSTR_W-1:0] instr,
   input logic [ADDR_W-1:0]  mem_addr,
   input logic               mem_rd,
   input logic               mem_wr,
   input logic [DATA_W-1:0]  mem_rdata,
   input logic               addr_fault,
   input logic               wb_en,
   input logic [DATA_W-1:0]  wb_data
);
   logic is_xfer;
   assign is_xfer = (instr[INSTR_W-1:INSTR_W-6] == 6'h23) ||
                    (instr[INSTR_W-1:INSTR_W-6] == 6'h2B);

   // R2
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   // R1
   accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && issue_ready && is_xfer) |=> (mem_rd || mem_wr || addr_fault));

   // R4
   fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      addr_fault |-> (!mem_rd && !mem_wr));

   // R4
   fault_nowb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      addr_fault |=> (!wb_en && issue_ready));

   // R5
   ld_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> ##1 wb_en);

   // R5
   wb_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> (wb_data == $past(mem_rdata)));

   // R6
   busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr || addr_fault || wb_en) |-> !issue_ready);

   // R7
   other_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && issue_ready && !is_xfer) |=> issue_ready);

   // R8
   store_nowb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |=> (!wb_en && issue_ready));

   generate
      if (STRICT_ALIGN) begin : g_al
         // R4
         aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mem_rd || mem_wr) |-> (mem_addr[1:0] == 2'b00));
      end
   endgenerate
endmodule

bind mem_xfer_agu agu_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .INSTR_W(INSTR_W), .STRICT_ALIGN(STRICT_ALIGN)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .issue_valid (issue_valid),
   .issue_ready (issue_ready),
   .instr       (instr),
   .mem_addr    (mem_addr),
   .mem_rd      (mem_rd),
   .mem_wr      (mem_wr),
   .mem_rdata   (mem_rdata),
   .addr_fault  (addr_fault),
   .wb_en       (wb_en),
   .wb_data     (wb_data)
);

// File: tb/tb_mem_xfer_agu.sv
module tb_mem_xfer_agu;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        issue_valid = 1'b0;
   logic        issue_ready;
   logic [31:0] instr = '0;
   logic [31:0] base_val = '0;
   logic [31:0] store_val = '0;
   logic [31:0] mem_addr;
   logic        mem_rd, mem_wr;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        addr_fault;
   logic        wb_en;
   logic [4:0]  wb_reg;
   logic [31:0] wb_data;

   int total = 0;
   int bad   = 0;
   localparam logic [31:0] MKEY = 32'h5A5A_0F0F;

   always #5 clk = ~clk;

   mem_xfer_agu dut (
      .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_ready(issue_ready),
      .instr(instr), .base_val(base_val), .store_val(store_val),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .addr_fault(addr_fault), .wb_en(wb_en),
      .wb_reg(wb_reg), .wb_data(wb_data)
   );

   // memory model: data for an address is a fixed function of it, one cycle late
   always @(posedge clk) begin
      if (mem_rd) mem_rdata <= mem_addr ^ MKEY;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] rt,
                                      input logic [15:0] off);
      return {op, 5'd7, rt, off};
   endfunction

   task automatic offer(input logic [31:0] iw, input logic [31:0] b, input logic [31:0] sv);
      @(negedge clk);
      while (!issue_ready) @(negedge clk);
      instr = iw; base_val = b; store_val = sv; issue_valid = 1'b1;
      @(negedge clk);
      issue_valid = 1'b0;
   endtask

   task automatic t_load(input logic [4:0] rt, input logic [31:0] b,
                         input logic [15:0] off, input logic [31:0] ea);
      offer(mk(6'h23, rt, off), b, 32'h0);
      chk("R1 load address", mem_addr, ea);
      chk("R2 load rd", {31'd0, mem_rd}, 32'd1);
      chk("R2 load no wr", {31'd0, mem_wr}, 32'd0);
      @(negedge clk);
      chk("R2 rd one cycle", {31'd0, mem_rd}, 32'd0);
      chk("R5 no early wb", {31'd0, wb_en}, 32'd0);
      @(negedge clk);
      chk("R5 wb_en", {31'd0, wb_en}, 32'd1);
      chk("R5 wb_reg", {27'd0, wb_reg}, {27'd0, rt});
      chk("R5 wb_data", wb_data, ea ^ MKEY);
      @(negedge clk);
      chk("R5 wb one cycle", {31'd0, wb_en}, 32'd0);
      chk("R6 idle after load", {31'd0, issue_ready}, 32'd1);
   endtask

   task automatic t_store(input logic [31:0] b, input logic [15:0] off,
                          input logic [31:0] sv, input logic [31:0] ea);
      offer(mk(6'h2B, 5'd12, off), b, sv);
      chk("R1 store address", mem_addr, ea);
      chk("R3 store wr", {31'd0, mem_wr}, 32'd1);
      chk("R3 store no rd", {31'd0, mem_rd}, 32'd0);
      chk("R3 store data", mem_wdata, sv);
      @(negedge clk);
      chk("R3 wr one cycle", {31'd0, mem_wr}, 32'd0);
      chk("R8 store no wb", {31'd0, wb_en}, 32'd0);
      @(negedge clk);
      chk("R8 store no wb later", {31'd0, wb_en}, 32'd0);
   endtask

   task automatic t_misal(input logic [5:0] op, input logic [31:0] b, input logic [15:0] off);
      offer(mk(op, 5'd9, off), b, 32'hDEAD_BEEF);
      chk("R4 fault pulse", {31'd0, addr_fault}, 32'd1);
      chk("R4 no strobe", {30'd0, mem_rd, mem_wr}, 32'd0);
      @(negedge clk);
      chk("R4 fault one cycle", {31'd0, addr_fault}, 32'd0);
      chk("R4 ready after fault", {31'd0, issue_ready}, 32'd1);
      @(negedge clk);
      chk("R4 no wb after fault", {31'd0, wb_en}, 32'd0);
   endtask

   task automatic t_other(input logic [31:0] iw);
      offer(iw, 32'h0000_1000, 32'h1);
      chk("R7 ignored no strobe", {29'd0, mem_rd, mem_wr, addr_fault}, 32'd0);
      chk("R7 stays ready", {31'd0, issue_ready}, 32'd1);
      @(negedge clk);
      chk("R7 no wb", {31'd0, wb_en}, 32'd0);
   endtask

   task automatic t_busy();
      offer(mk(6'h23, 5'd4, 16'h0010), 32'h0000_2000, 32'h0);
      // keep a store on offer while the load is in flight
      instr = mk(6'h2B, 5'd1, 16'h0000); base_val = 32'h0000_3000; issue_valid = 1'b1;
      chk("R6 busy ready low", {31'd0, issue_ready}, 32'd0);
      chk("R6 load rd", {31'd0, mem_rd}, 32'd1);
      @(negedge clk);
      chk("R6 no wr while busy", {31'd0, mem_wr}, 32'd0);
      issue_valid = 1'b0;
      @(negedge clk);
      chk("R6 load wb intact", wb_data, 32'h0000_2010 ^ MKEY);
      chk("R6 no wr while busy 2", {31'd0, mem_wr}, 32'd0);
      @(negedge clk);
      @(negedge clk);
      chk("R6 ignored store never issued", {30'd0, mem_wr, addr_fault}, 32'd0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R9 reset state
      chk("R9 ready", {31'd0, issue_ready}, 32'd1);
      chk("R9 quiet", {28'd0, mem_rd, mem_wr, addr_fault, wb_en}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 quiet after release", {28'd0, mem_rd, mem_wr, addr_fault, wb_en}, 32'd0);

      t_load(5'd10, 32'h0000_0000, 16'h0020, 32'h0000_0020);
      t_store(32'h0004_0014, 16'hFFF8, 32'hFFFF_FFFF, 32'h0004_000C);
      t_load(5'd31, 32'hFFFF_FFFC, 16'h0008, 32'h0000_0004);
      t_store(32'h0000_0004, 16'h8000, 32'h1234_5678, 32'hFFFF_8004);
      t_load(5'd6, 32'h0040_0000, 16'h0060, 32'h0040_0060);
      t_store(32'h000A_E400, 16'h0030, 32'hCAFE_F00D, 32'h000A_E430);
      t_misal(6'h23, 32'h0001_4430, 16'h0002);
      t_misal(6'h2B, 32'h000B_0730, 16'h0007);
      t_misal(6'h23, 32'h0000_0001, 16'h0000);
      t_other(32'h2003_0007);
      t_other(32'h0064_2820);
      t_busy();
      t_load(5'd0, 32'h7FFF_FFF0, 16'h7FFC, 32'h8000_7FEC);

      disable watchdog;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule